// File: doc/BRIEF.md
# Hashed Page Table Walker

This block turns a 32-bit effective address into a real page number. It searches a hashed page table that sits in ordinary memory. The caller supplies four things:

- the fields of the segment register already chosen for the access: a 24-bit segment identifier, a user key bit, a supervisor key bit and a no-execute flag;
- the effective address;
- the access kind (load, store or instruction fetch) and the privilege level;
- the table base and the table mask.

A one-cycle `start` pulse launches a walk. The walker reads candidate entries through a single word-wide memory port that uses a request/acknowledge handshake.

The search runs in two passes:

1. The primary pass hashes the segment identifier with the page index, selects a group of eight two-word entries and scans them in order.
2. If none of the eight entries matches, the secondary pass repeats the scan in the group selected by the complemented hash.

On a match the walker works out the access rights from the privilege key and the entry's two-bit protection field. It sets the referenced bit and, for a granted store, the changed bit. It writes the entry's second word back only if one of those bits actually changed.

When the walk ends, `done` pulses for one cycle. At that point the hit flag, the grant flag, the real page number and the rights set are valid. They stay valid until the next walk starts. The block raises no exceptions; the caller acts on the hit and grant flags.

Top module: `hpt_walker`

## Requirements
- R1: While reset is held and on the first cycle after it, `done`, `hit`, `grant` and `mem_req` are 0.
- R2: Word 0 of an entry matches only when all four of these hold: bit 31 (valid) is 1; bits 30:7 equal the segment identifier; bits 5:0 equal effective-address bits 27:22; bit 6 (secondary flag) equals the current pass (0 primary, 1 secondary).
- R3: The primary group address is `(base & ~mask) | ((hash << 6) & mask)`, where hash = segment identifier XOR effective-address bits 27:12. Entry i of a group sits at group + 8*i with word 1 at +4. Entries are read in ascending order and the first match wins.
- R4: If all eight primary entries miss, the same scan runs over the group built from the bitwise complement of the hash. If all sixteen entries miss, `done` comes with `hit`=0, `grant`=0 and `perm`=0, and nothing is written.
- R5: The key is `seg_ku` for a user-mode access (`user`=1) and `seg_ks` for a supervisor access.
- R6: The rights set `perm` is {execute, write, read} in bits 2:0. It depends on the key and on the protection field, word-1 bits 1:0:

  | Key | Field 0 | Field 1 | Field 2 | Field 3 |
  |-----|---------|---------|---------|---------|
  | 0 | read and write | read and write | read and write | read only |
  | 1 | nothing | read only | read and write | read only |

  Execute is added when `seg_nx` is 0.
- R7: Access kinds are encoded 0 load, 1 store, 2 fetch. The access is granted when `perm` holds the right the kind needs: read for a load, write for a store, execute for a fetch.
- R8: On a grant, word-1 bit 8 (referenced) is set, and bit 7 (changed) is set as well for a store. Word 1 is written back only when that update changed it. A denied access writes nothing.
- R9: If the changed bit is clear after the update, the write right is removed from the returned `perm`.
- R10: On a hit, `rpn` equals word-1 bits 31:12 of the matching entry.
- R11: While `mem_req` is high and `mem_ack` is low, `mem_addr`, `mem_we` and `mem_wdata` hold their values. Read data is taken in the cycle `mem_ack` is high, whatever the latency.
- R12: `done` is high for exactly one cycle per walk.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch a walk (sampled when idle) |
| ea | input | 32 | Effective address |
| acc | input | 2 | Access kind: 0 load, 1 store, 2 fetch |
| user | input | 1 | 1 for a user-mode access |
| seg_vsid | input | 24 | Segment identifier |
| seg_ku | input | 1 | User key bit of the segment |
| seg_ks | input | 1 | Supervisor key bit of the segment |
| seg_nx | input | 1 | Segment no-execute flag |
| tbl_base | input | 32 | Table base address |
| tbl_mask | input | 32 | Table offset mask |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory acknowledge |
| mem_rdata | input | 32 | Memory read data, valid with acknowledge |
| done | output | 1 | Walk finished (one-cycle pulse) |
| hit | output | 1 | A matching entry was found |
| grant | output | 1 | Access allowed |
| rpn | output | 20 | Real page number |
| perm | output | 3 | Rights {execute, write, read} |

## Verification
The hardest case to reach is a secondary-pass hit that must skip near-misses along the way. The primary group holds an entry whose tag matches but whose secondary flag is set. The secondary group holds an entry whose tag matches but whose flag is clear, placed ahead of the true entry. The bench computes both group addresses from the hash formula and loads them, so the walker has to reject each decoy for the right reason before it reaches the last real entry. A slow-memory case lengthens the acknowledge latency during a walk that ends in a writeback. The responder then compares address, write enable and write data on every waiting cycle.

// File: rtl/hpt_pkg.sv
`timescale 1ns/1ps
package hpt_pkg;
   typedef enum logic [1:0] {
      ACC_LOAD  = 2'd0,
      ACC_STORE = 2'd1,
      ACC_FETCH = 2'd2
   } acc_e;

   localparam int RIGHT_R = 0;
   localparam int RIGHT_W = 1;
   localparam int RIGHT_X = 2;

   typedef enum logic [2:0] {
      WS_IDLE,
      WS_RD0,
      WS_RD1,
      WS_NEXT,
      WS_SWAP,
      WS_WB,
      WS_DONE
   } walk_e;
endpackage

// File: rtl/hpt_hash.sv
`timescale 1ns/1ps
module hpt_hash #(
   parameter int AW     = 32,
   parameter int VSID_W = 24,
   parameter int PIDX_W = 16,
   parameter int GSHIFT = 6
) (
   input  logic [VSID_W-1:0] vsid_i,
   input  logic [PIDX_W-1:0] pidx_i,
   input  logic [AW-1:0]     base_i,
   input  logic [AW-1:0]     mask_i,
   output logic [AW-1:0]     grp_pri_o,
   output logic [AW-1:0]     grp_sec_o
);
   logic [VSID_W-1:0] hash_pri;
   logic [VSID_W-1:0] hash_sec;
   logic [AW-1:0]     base_clr;

   always_comb begin
      hash_pri  = vsid_i ^ VSID_W'(pidx_i);
      hash_sec  = ~hash_pri;
      base_clr  = base_i & ~mask_i;
      grp_pri_o = base_clr | ((AW'(hash_pri) << GSHIFT) & mask_i);
      grp_sec_o = base_clr | ((AW'(hash_sec) << GSHIFT) & mask_i);
   end
endmodule

// File: rtl/hpt_perm.sv
`timescale 1ns/1ps
module hpt_perm
   import hpt_pkg::*;
#(
   parameter int DW       = 32,
   parameter int REF_BIT  = 8,
   parameter int CHG_BIT  = 7,
   parameter bit HONOR_NX = 1'b1
) (
   input  logic          user_i,
   input  logic          ku_i,
   input  logic          ks_i,
   input  logic          nx_i,
   input  acc_e          acc_i,
   input  logic [DW-1:0] w1_i,
   output logic [2:0]    perm_o,
   output logic          grant_o,
   output logic [DW-1:0] w1_new_o,
   output logic          wb_need_o
);
   logic       key;
   logic       x_ok;
   logic [1:0] rw;
   logic [2:0] raw;
   logic       store;

   generate
      if (HONOR_NX) begin : g_nx
         assign x_ok = ~nx_i;
      end else begin : g_nonx
         assign x_ok = 1'b1;
      end
   endgenerate

   always_comb begin
      key   = user_i ? ku_i : ks_i;
      store = (acc_i == ACC_STORE);
      unique case ({key, w1_i[1:0]})
         3'b0_00, 3'b0_01, 3'b0_10: rw = 2'b11;
         3'b0_11:                   rw = 2'b01;
         3'b1_00:                   rw = 2'b00;
         3'b1_10:                   rw = 2'b11;
         default:                   rw = 2'b01;
      endcase
      raw = {x_ok, rw};
      unique case (acc_i)
         ACC_STORE: grant_o = raw[RIGHT_W];
         ACC_FETCH: grant_o = raw[RIGHT_X];
         default:   grant_o = raw[RIGHT_R];
      endcase
      w1_new_o = w1_i;
      if (grant_o) begin
         w1_new_o[REF_BIT] = 1'b1;
         if (store) w1_new_o[CHG_BIT] = 1'b1;
      end
      wb_need_o = grant_o && (w1_new_o != w1_i);
      perm_o    = raw;
      if (!w1_new_o[CHG_BIT]) perm_o[RIGHT_W] = 1'b0;
   end
endmodule

// File: rtl/hpt_walker.sv
`timescale 1ns/1ps
module hpt_walker
   import hpt_pkg::*;
#(
   parameter int AW            = 32,
   parameter int DW            = 32,
   parameter int VSID_W        = 24,
   parameter int PAGE_SHIFT    = 12,
   parameter int PIDX_W        = 16,
   parameter int API_W         = 6,
   parameter int GROUP_ENTRIES = 8,
   parameter bit HONOR_NX      = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [AW-1:0]     ea,
   input  logic [1:0]        acc,
   input  logic              user,
   input  logic [VSID_W-1:0] seg_vsid,
   input  logic              seg_ku,
   input  logic              seg_ks,
   input  logic              seg_nx,
   input  logic [AW-1:0]     tbl_base,
   input  logic [AW-1:0]     tbl_mask,
   output logic              mem_req,
   output logic              mem_we,
   output logic [AW-1:0]     mem_addr,
   output logic [DW-1:0]     mem_wdata,
   input  logic              mem_ack,
   input  logic [DW-1:0]     mem_rdata,
   output logic              done,
   output logic              hit,
   output logic              grant,
   output logic [DW-PAGE_SHIFT-1:0] rpn,
   output logic [2:0]        perm
);
   localparam int ENT_BYTES = 2 * (DW / 8);
   localparam int W1_OFF    = DW / 8;
   localparam int GSHIFT    = $clog2(GROUP_ENTRIES * ENT_BYTES);
   localparam int IW        = $clog2(GROUP_ENTRIES);
   localparam int ESHIFT    = $clog2(ENT_BYTES);
   localparam int H_BIT     = API_W;
   localparam int RPN_W     = DW - PAGE_SHIFT;
   localparam logic [IW-1:0] LAST_IDX = IW'(GROUP_ENTRIES - 1);

   generate
      if (VSID_W + API_W + 2 != DW) begin : g_bad_w0
         $error("entry word 0 layout does not fill the data width");
      end
      if ((GROUP_ENTRIES & (GROUP_ENTRIES - 1)) != 0 || GROUP_ENTRIES < 2) begin : g_bad_grp
         $error("GROUP_ENTRIES must be a power of two of at least 2");
      end
      if (PAGE_SHIFT + PIDX_W > AW || API_W > PIDX_W || PIDX_W > VSID_W) begin : g_bad_pidx
         $error("page index fields do not fit");
      end
   endgenerate

   walk_e             st_q;
   logic              pass_q;
   logic [IW-1:0]     idx_q;
   logic [PIDX_W-1:0] pidx_q;
   acc_e              acc_q;
   logic              user_q, ku_q, ks_q, nx_q;
   logic [VSID_W-1:0] vsid_q;
   logic [AW-1:0]     base_q, mask_q;
   logic [DW-1:0]     w1_q;
   logic              hit_q, grant_q;
   logic [RPN_W-1:0]  rpn_q;
   logic [2:0]        perm_q;

   logic [AW-1:0] grp_pri, grp_sec, grp, ent_addr;
   logic          match;
   logic [2:0]    pc_perm;
   logic          pc_grant, pc_wb;
   logic [DW-1:0] pc_w1;

   hpt_hash #(.AW(AW), .VSID_W(VSID_W), .PIDX_W(PIDX_W), .GSHIFT(GSHIFT)) u_hash (
      .vsid_i(vsid_q), .pidx_i(pidx_q), .base_i(base_q), .mask_i(mask_q),
      .grp_pri_o(grp_pri), .grp_sec_o(grp_sec)
   );

   hpt_perm #(.DW(DW), .HONOR_NX(HONOR_NX)) u_perm (
      .user_i(user_q), .ku_i(ku_q), .ks_i(ks_q), .nx_i(nx_q), .acc_i(acc_q),
      .w1_i(mem_rdata), .perm_o(pc_perm), .grant_o(pc_grant),
      .w1_new_o(pc_w1), .wb_need_o(pc_wb)
   );

   always_comb begin
      grp      = pass_q ? grp_sec : grp_pri;
      ent_addr = grp + (AW'(idx_q) << ESHIFT);
      match    = mem_rdata[DW-1]
               && (mem_rdata[H_BIT] == pass_q)
               && (mem_rdata[DW-2 -: VSID_W] == vsid_q)
               && (mem_rdata[API_W-1:0] == pidx_q[PIDX_W-1 -: API_W]);
      mem_req   = (st_q == WS_RD0) || (st_q == WS_RD1) || (st_q == WS_WB);
      mem_we    = (st_q == WS_WB);
      mem_addr  = (st_q == WS_RD0) ? ent_addr : ent_addr + AW'(W1_OFF);
      mem_wdata = w1_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q    <= WS_IDLE;
         pass_q  <= 1'b0;
         idx_q   <= '0;
         pidx_q  <= '0;
         acc_q   <= ACC_LOAD;
         user_q  <= 1'b0;
         ku_q    <= 1'b0;
         ks_q    <= 1'b0;
         nx_q    <= 1'b0;
         vsid_q  <= '0;
         base_q  <= '0;
         mask_q  <= '0;
         w1_q    <= '0;
         hit_q   <= 1'b0;
         grant_q <= 1'b0;
         rpn_q   <= '0;
         perm_q  <= '0;
      end else begin
         unique case (st_q)
            WS_IDLE: if (start) begin
               pidx_q  <= ea[PAGE_SHIFT +: PIDX_W];
               acc_q   <= acc_e'(acc);
               user_q  <= user;
               ku_q    <= seg_ku;
               ks_q    <= seg_ks;
               nx_q    <= seg_nx;
               vsid_q  <= seg_vsid;
               base_q  <= tbl_base;
               mask_q  <= tbl_mask;
               pass_q  <= 1'b0;
               idx_q   <= '0;
               hit_q   <= 1'b0;
               grant_q <= 1'b0;
               rpn_q   <= '0;
               perm_q  <= '0;
               st_q    <= WS_RD0;
            end
            WS_RD0: if (mem_ack) st_q <= match ? WS_RD1 : WS_NEXT;
            WS_RD1: if (mem_ack) begin
               hit_q   <= 1'b1;
               grant_q <= pc_grant;
               perm_q  <= pc_perm;
               rpn_q   <= mem_rdata[DW-1:PAGE_SHIFT];
               w1_q    <= pc_w1;
               st_q    <= pc_wb ? WS_WB : WS_DONE;
            end
            WS_NEXT: begin
               if (idx_q == LAST_IDX) begin
                  st_q <= pass_q ? WS_DONE : WS_SWAP;
               end else begin
                  idx_q <= idx_q + 1'b1;
                  st_q  <= WS_RD0;
               end
            end
            WS_SWAP: begin
               pass_q <= 1'b1;
               idx_q  <= '0;
               st_q   <= WS_RD0;
            end
            WS_WB:   if (mem_ack) st_q <= WS_DONE;
            default: st_q <= WS_IDLE;
         endcase
      end
   end

   assign done  = (st_q == WS_DONE);
   assign hit   = hit_q;
   assign grant = grant_q;
   assign rpn   = rpn_q;
   assign perm  = perm_q;

   // R11: request fields hold while waiting for acknowledge
   p_req_stable_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));
   // R8: a writeback always carries the referenced bit
   p_wb_sets_ref_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we) |-> mem_wdata[8]);
   // R3: a writeback targets word 1 of an entry
   p_wb_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we) |-> (mem_addr[ESHIFT-1:0] == ESHIFT'(W1_OFF)));
   // R12: done lasts one cycle
   p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R4: a miss reports no rights
   p_miss_clean_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !hit) |-> (!grant && perm == 3'b000));
   // R7: a granted store carries write right
   p_store_grant_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (done && grant && acc_q == ACC_STORE) |-> perm[RIGHT_W]);
endmodule

// File: tb/hpt_walker_tb.sv
`timescale 1ns/1ps
module hpt_walker_tb_top;
   localparam logic [31:0] BASE = 32'h0000_1000;
   localparam logic [31:0] MASK = 32'h0000_0FC0;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [31:0] ea = '0;
   logic [1:0]  acc = '0;
   logic        user = 1'b0;
   logic [23:0] seg_vsid = '0;
   logic        seg_ku = 1'b0, seg_ks = 1'b0, seg_nx = 1'b0;
   logic        mem_req, mem_we;
   logic [31:0] mem_addr, mem_wdata;
   logic        mem_ack = 1'b0;
   logic [31:0] mem_rdata = '0;
   logic        done, hit, grant;
   logic [19:0] rpn;
   logic [2:0]  perm;

   int checks = 0, fails = 0;
   int wr_cnt = 0, viol = 0, lat = 0, wcnt = 0;
   logic [31:0] h_addr, h_wdata;
   logic        h_we;
   logic [31:0] mem [0:2047];

   always #2 clk = ~clk;

   hpt_walker dut_i (
      .clk(clk), .rst_n(rst_n), .start(start), .ea(ea), .acc(acc), .user(user),
      .seg_vsid(seg_vsid), .seg_ku(seg_ku), .seg_ks(seg_ks), .seg_nx(seg_nx),
      .tbl_base(BASE), .tbl_mask(MASK),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_ack(mem_ack), .mem_rdata(mem_rdata),
      .done(done), .hit(hit), .grant(grant), .rpn(rpn), .perm(perm)
   );

   // memory responder with programmable latency (R11 stability checked here)
   always @(negedge clk) begin
      if (!rst_n) begin
         mem_ack = 1'b0;
         wcnt = 0;
      end else if (mem_ack) begin
         mem_ack = 1'b0;
      end else if (mem_req) begin
         if (wcnt == 0) begin
            h_addr = mem_addr; h_we = mem_we; h_wdata = mem_wdata;
         end else if (h_addr !== mem_addr || h_we !== mem_we || h_wdata !== mem_wdata) begin
            viol++;
         end
         if (wcnt >= lat) begin
            wcnt = 0;
            mem_ack = 1'b1;
            if (mem_we) begin
               mem[mem_addr[12:2]] = mem_wdata;
               wr_cnt++;
            end else begin
               mem_rdata = mem[mem_addr[12:2]];
            end
         end else begin
            wcnt++;
         end
      end
   end

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   function automatic logic [31:0] grp(input logic [23:0] v, input logic [31:0] a, input logic sec);
      logic [23:0] h;
      h = v ^ {8'h00, a[27:12]};
      if (sec) h = ~h;
      return (BASE & ~MASK) | (({8'h00, h} << 6) & MASK);
   endfunction

   function automatic logic [31:0] mk0(input logic vld, input logic [23:0] v, input logic hflag, input logic [5:0] api);
      return {vld, v, hflag, api};
   endfunction

   function automatic logic [31:0] mk1(input logic [19:0] r, input logic rb, input logic cb, input logic [1:0] pp);
      return {r, 3'b000, rb, cb, 5'b00000, pp};
   endfunction

   task automatic clear_mem();
      for (int i = 0; i < 2048; i++) mem[i] = '0;
   endtask

   task automatic put(input logic [31:0] g, input int slot, input logic [31:0] w0, input logic [31:0] w1);
      mem[(g[12:2] + 11'(slot * 2))]     = w0;
      mem[(g[12:2] + 11'(slot * 2 + 1))] = w1;
   endtask

   function automatic logic [31:0] rd1(input logic [31:0] g, input int slot);
      return mem[(g[12:2] + 11'(slot * 2 + 1))];
   endfunction

   task automatic run(input logic [1:0] a, input logic u, input logic ku, input logic ks,
                      input logic nx, input logic [31:0] e, input logic [23:0] v);
      int n;
      @(negedge clk);
      acc = a; user = u; seg_ku = ku; seg_ks = ks; seg_nx = nx; ea = e; seg_vsid = v;
      wr_cnt = 0;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      n = 0;
      while (!done && n < 3000) begin
         @(negedge clk);
         n++;
      end
      if (n >= 3000) begin
         checks++; fails++;
         $display("FAIL R12 watchdog actual=%0d expected=<3000", n);
      end
   endtask

   task automatic after_done();
      @(negedge clk);
      chk("R12", "done pulse", {31'b0, done}, 32'd0);
   endtask

   localparam logic [23:0] VS = 24'h12_3456;
   localparam logic [31:0] EA = 32'h0ABC_D000;
   localparam logic [5:0]  API = 6'h2A;

   task automatic t_reset();
      chk("R1", "done", {31'b0, done}, 0);
      chk("R1", "hit", {31'b0, hit}, 0);
      chk("R1", "grant", {31'b0, grant}, 0);
      chk("R1", "mem_req", {31'b0, mem_req}, 0);
   endtask

   task automatic t_primary_load();
      logic [31:0] g;
      clear_mem();
      g = grp(VS, EA, 1'b0);
      put(g, 2, mk0(1, VS, 0, API ^ 6'h01), mk1(20'h99999, 0, 0, 2'd2));
      put(g, 3, mk0(1, VS, 0, API), mk1(20'h11111, 0, 0, 2'd2));
      run(2'd0, 0, 0, 0, 0, EA, VS);
      chk("R2", "hit", {31'b0, hit}, 1);
      chk("R10", "rpn", {12'b0, rpn}, 32'h11111);
      chk("R7", "grant load", {31'b0, grant}, 1);
      chk("R9", "perm w removed", {29'b0, perm}, 32'b101);
      chk("R8", "write count", wr_cnt, 1);
      chk("R8", "word1 ref set", rd1(g, 3), mk1(20'h11111, 1, 0, 2'd2));
      after_done();
   endtask

   task automatic t_order();
      logic [31:0] g;
      clear_mem();
      g = grp(VS, EA, 1'b0);
      put(g, 2, mk0(1, VS, 0, API), mk1(20'h22222, 1, 1, 2'd0));
      put(g, 6, mk0(1, VS, 0, API), mk1(20'h66666, 1, 1, 2'd0));
      run(2'd0, 0, 0, 0, 0, EA, VS);
      chk("R3", "first match rpn", {12'b0, rpn}, 32'h22222);
      chk("R8", "no write when bits set", wr_cnt, 0);
      chk("R9", "perm with changed set", {29'b0, perm}, 32'b111);
      after_done();
   endtask

   task automatic t_store();
      logic [31:0] g;
      clear_mem();
      g = grp(VS, EA, 1'b0);
      put(g, 0, mk0(1, VS, 0, API), mk1(20'h44444, 0, 0, 2'd1));
      run(2'd1, 0, 0, 0, 0, EA, VS);
      chk("R7", "store grant", {31'b0, grant}, 1);
      chk("R8", "store writes", wr_cnt, 1);
      chk("R8", "ref and chg set", rd1(g, 0), mk1(20'h44444, 1, 1, 2'd1));
      chk("R9", "store perm", {29'b0, perm}, 32'b111);
      after_done();
   endtask

   task automatic t_keys();
      logic [31:0] g;
      clear_mem();
      g = grp(VS, EA, 1'b0);
      put(g, 1, mk0(1, VS, 0, API), mk1(20'h0AAAA, 0, 0, 2'd0));
      run(2'd0, 1, 1, 0, 0, EA, VS);   // user, user key 1 -> key 1, field 0
      chk("R5", "user key denies", {31'b0, grant}, 0);
      chk("R6", "key1 field0 perm", {29'b0, perm}, 32'b100);
      chk("R8", "denial no write", wr_cnt, 0);
      chk("R8", "word1 untouched", rd1(g, 1), mk1(20'h0AAAA, 0, 0, 2'd0));
      run(2'd0, 0, 1, 0, 0, EA, VS);   // supervisor uses ks=0 -> key 0
      chk("R5", "supervisor key0 grant", {31'b0, grant}, 1);
      chk("R6", "key0 field0 perm", {29'b0, perm}, 32'b101);
      put(g, 1, mk0(1, VS, 0, API), mk1(20'h0AAAA, 1, 1, 2'd3));
      run(2'd1, 0, 0, 1, 0, EA, VS);   // key 1, field 3, store
      chk("R6", "key1 field3 store denied", {31'b0, grant}, 0);
      chk("R6", "key1 field3 perm", {29'b0, perm}, 32'b101);
      put(g, 1, mk0(1, VS, 0, API), mk1(20'h0AAAA, 1, 1, 2'd2));
      run(2'd1, 0, 0, 1, 0, EA, VS);   // key 1, field 2, store
      chk("R6", "key1 field2 store", {31'b0, grant}, 1);
      chk("R6", "key1 field2 perm", {29'b0, perm}, 32'b111);
      after_done();
   endtask

   task automatic t_nx();
      logic [31:0] g;
      clear_mem();
      g = grp(VS, EA, 1'b0);
      put(g, 4, mk0(1, VS, 0, API), mk1(20'h0F0F0, 1, 1, 2'd2));
      run(2'd2, 0, 0, 0, 1, EA, VS);
      chk("R7", "fetch nx denied", {31'b0, grant}, 0);
      chk("R6", "nx perm", {29'b0, perm}, 32'b011);
      chk("R8", "nx no write", wr_cnt, 0);
      run(2'd2, 0, 0, 0, 0, EA, VS);
      chk("R7", "fetch granted", {31'b0, grant}, 1);
      after_done();
   endtask

   task automatic t_secondary();
      logic [31:0] gp, gs;
      clear_mem();
      gp = grp(VS, EA, 1'b0);
      gs = grp(VS, EA, 1'b1);
      put(gp, 0, mk0(1, VS, 1, API), mk1(20'hAAAAA, 1, 0, 2'd3));
      put(gs, 1, mk0(1, VS, 0, API), mk1(20'hBBBBB, 1, 0, 2'd3));
      put(gs, 7, mk0(1, VS, 1, API), mk1(20'h55555, 1, 0, 2'd3));
      run(2'd0, 0, 0, 0, 0, EA, VS);
      chk("R4", "secondary hit", {31'b0, hit}, 1);
      chk("R4", "secondary rpn", {12'b0, rpn}, 32'h55555);
      chk("R6", "key0 field3 perm", {29'b0, perm}, 32'b101);
      chk("R8", "ref already set no write", wr_cnt, 0);
      after_done();
   endtask

   task automatic t_miss();
      logic [31:0] g;
      clear_mem();
      g = grp(VS, EA, 1'b0);
      put(g, 0, mk0(0, VS, 0, API), mk1(20'h12345, 0, 0, 2'd2));
      put(g, 5, mk0(1, VS ^ 24'h1, 0, API), mk1(20'h12345, 0, 0, 2'd2));
      run(2'd1, 0, 0, 0, 0, EA, VS);
      chk("R4", "miss hit", {31'b0, hit}, 0);
      chk("R2", "miss grant", {31'b0, grant}, 0);
      chk("R4", "miss perm", {29'b0, perm}, 0);
      chk("R4", "miss no write", wr_cnt, 0);
      after_done();
   endtask

   task automatic t_slow();
      logic [31:0] g;
      clear_mem();
      lat = 3;
      g = grp(VS, EA, 1'b1);
      put(g, 2, mk0(1, VS, 1, API), mk1(20'h77777, 0, 0, 2'd2));
      run(2'd1, 0, 0, 0, 0, EA, VS);
      chk("R11", "slow rpn", {12'b0, rpn}, 32'h77777);
      chk("R11", "slow write", rd1(g, 2), mk1(20'h77777, 1, 1, 2'd2));
      chk("R11", "request stability", viol, 0);
      lat = 0;
      after_done();
   endtask

   initial begin
      clear_mem();
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_primary_load();
      t_order();
      t_store();
      t_keys();
      t_nx();
      t_secondary();
      t_miss();
      t_slow();
      chk("R11", "request stability total", viol, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule